// File: doc/BRIEF.md
# Directional Talk Attenuator and Center Clipper

This block is a per-sample stage that sits on the output side of a mu-law speech path running at 8 kHz. It takes one receive-direction sample and one send-direction sample per frame. Two activity flags come from a level detector elsewhere in the chip. The block attenuates exactly one of the two directions by roughly 6 dB, and the talk state decides which one. Attenuating means halving the linear magnitude and encoding the result back to mu-law.

The send output can also be center clipped. A send sample whose linear level is below a small threshold is replaced by the mu-law idle code, which removes low-level residual noise. Both outputs are registered. They change one clock after the frame strobe, and a one-cycle valid pulse marks that change.

Top module: `talk_atten_clip`

## Requirements
- R1: While `rst_n` is low, and after its release until the first strobe, `rx_out` and `tx_out` read 0xFF and `out_vld` is 0.
- R2: A high `smp_stb` in one clock makes `out_vld` high for exactly the following clock, and the outputs take their new values on that same edge. Without a strobe, `out_vld` is 0 and both outputs hold their values.
- R3: When `att_n` is 1 the attenuator is disabled. Both samples pass unchanged unless the R8 clipper acts.
- R4: When `att_n` is 0 and only `rx_act` is high, `tx_out` carries the halved send sample and `rx_out` equals `rx_in`.
- R5: When `att_n` is 0 and `tx_act` is high, `rx_out` carries the halved receive sample and the send sample is not attenuated. This holds whether `rx_act` is high or low.
- R6: When `att_n` is 0 and both activity flags are low, both samples pass unattenuated.
- R7: The linear magnitude of a code c is defined using u = ~c. The sign is u[7], the exponent e is u[6:4] and the mantissa m is u[3:0]. The magnitude is ((2m+33)<<e)-33. Halving takes floor(magnitude/2) and keeps the sign. Encoding uses b = magnitude+33 and the highest set bit p of b, with p in 5..12. It sets e = p-5 and m = (b>>(e+1)) & 15, and emits ~{sign,e,m}.
- R8: When `clip_en` is 1, a send sample whose linear magnitude after any attenuation is strictly below `CLIP_LEVEL` (default 12) becomes 0xFF. A magnitude equal to or above the threshold is kept. When `clip_en` is 0, no clipping happens.
- R9: The clipper never alters the receive path. A small receive sample passes unchanged when `clip_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| smp_stb | input | 1 | One-cycle frame strobe |
| rx_in | input | 8 | Receive-direction mu-law sample |
| tx_in | input | 8 | Send-direction mu-law residual |
| rx_act | input | 1 | Receive talker active |
| tx_act | input | 1 | Send talker active |
| att_n | input | 1 | Attenuator enable, active low |
| clip_en | input | 1 | Center clip enable, active high |
| rx_out | output | 8 | Processed receive sample |
| tx_out | output | 8 | Processed send sample |
| out_vld | output | 1 | Output update pulse |

## Verification
The assertions assume several things about the inputs. Samples, flags and enables are valid and steady in the cycle the strobe is high. The strobe is a single-cycle pulse. Any 8-bit code is legal. The bench respects this by changing every input on the falling edge and raising the strobe for one clock per frame. It then lets at least one idle clock pass, so the hold and valid-drop properties are exercised between frames. Its table covers each talk state. It includes both signs, full-scale codes, the exact clip threshold, and a sample that is clipped only because halving brought it below the threshold.

// File: rtl/talk_atten_clip.sv
module talk_atten_clip #(
  parameter int CLIP_LEVEL = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_stb,
  input  logic [7:0] rx_in,
  input  logic [7:0] tx_in,
  input  logic       rx_act,
  input  logic       tx_act,
  input  logic       att_n,
  input  logic       clip_en,
  output logic [7:0] rx_out,
  output logic [7:0] tx_out,
  output logic       out_vld
);
  localparam logic [12:0] CLIP_LVL = 13'(CLIP_LEVEL);
  localparam logic [7:0]  IDLE     = 8'hFF;

  function automatic logic [12:0] mu_mag(input logic [7:0] c);
    logic [7:0]  u;
    logic [12:0] t;
    u = ~c;
    t = 13'({u[3:0], 1'b0}) + 13'd33;
    return (t << u[6:4]) - 13'd33;
  endfunction

  function automatic logic [7:0] mu_enc(input logic s, input logic [12:0] m);
    logic [12:0] b;
    logic [2:0]  e;
    logic [12:0] sh;
    b = m + 13'd33;
    e = 3'd0;
    for (int i = 0; i < 8; i++)
      if (b[5+i]) e = 3'(i);
    sh = b >> (e + 3'd1);
    return ~{s, e, sh[3:0]};
  endfunction

  logic [12:0] rx_mag, tx_mag, tx_lvl;
  logic        rx_cut, tx_cut;
  logic [7:0]  rx_nxt, tx_nxt;

  assign rx_mag = mu_mag(rx_in);
  assign tx_mag = mu_mag(tx_in);
  assign rx_cut = ~att_n & tx_act;
  assign tx_cut = ~att_n & rx_act & ~tx_act;
  assign tx_lvl = tx_cut ? (tx_mag >> 1) : tx_mag;

  assign rx_nxt = rx_cut ? mu_enc(~rx_in[7], rx_mag >> 1) : rx_in;
  assign tx_nxt = (clip_en && tx_lvl < CLIP_LVL) ? IDLE :
                  tx_cut ? mu_enc(~tx_in[7], tx_lvl) : tx_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_out  <= IDLE;
      tx_out  <= IDLE;
      out_vld <= 1'b0;
    end else begin
      out_vld <= smp_stb;
      if (smp_stb) begin
        rx_out <= rx_nxt;
        tx_out <= tx_nxt;
      end
    end
  end

  assert_vld_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> out_vld);
  assert_vld_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> !out_vld);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> ($stable(rx_out) && $stable(tx_out)));
  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && att_n && !clip_en) |=>
      (rx_out == $past(rx_in) && tx_out == $past(tx_in)));
  assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && !rx_act && !tx_act && !clip_en) |=>
      (rx_out == $past(rx_in) && tx_out == $past(tx_in)));
  assert_rx_shrink_R5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> (mu_mag(rx_out) <= mu_mag($past(rx_in)) &&
                 rx_out[7] == $past(rx_in[7])));
  assert_clip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && clip_en && mu_mag(tx_in) < CLIP_LVL) |=> (tx_out == IDLE));
endmodule

// File: tb/talk_atten_clip_tb_top.sv
module talk_atten_clip_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_stb = 1'b0;
  logic [7:0] rx_in = 8'h00, tx_in = 8'h00;
  logic       rx_act = 1'b0, tx_act = 1'b0, att_n = 1'b1, clip_en = 1'b0;
  logic [7:0] rx_out, tx_out;
  logic       out_vld;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  talk_atten_clip dut_i (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .rx_in(rx_in), .tx_in(tx_in),
    .rx_act(rx_act), .tx_act(tx_act), .att_n(att_n), .clip_en(clip_en),
    .rx_out(rx_out), .tx_out(tx_out), .out_vld(out_vld)
  );

  // {req, rx_in, tx_in, rx_act, tx_act, att_n, clip_en, exp_rx, exp_tx}
  localparam logic [39:0] VEC [16] = '{
    {4'd3, 8'h80, 8'hC0, 4'b1010, 8'h80, 8'hC0}, // R3 attenuator off
    {4'd4, 8'h80, 8'hC0, 4'b1000, 8'h80, 8'hCF}, // R4 receive talker only
    {4'd5, 8'h80, 8'hC0, 4'b0100, 8'h90, 8'hC0}, // R5 send talker only
    {4'd5, 8'h80, 8'hC0, 4'b1100, 8'h90, 8'hC0}, // R5 both talkers
    {4'd6, 8'h80, 8'hC0, 4'b0000, 8'h80, 8'hC0}, // R6 nobody talking
    {4'd7, 8'h00, 8'hA5, 4'b0100, 8'h10, 8'hA5}, // R7 negative full scale
    {4'd7, 8'hA5, 8'h25, 4'b1000, 8'hA5, 8'h34}, // R7 negative send halved
    {4'd7, 8'h25, 8'hA5, 4'b1100, 8'h34, 8'hA5}, // R7 negative receive halved
    {4'd8, 8'hFA, 8'hFA, 4'b0011, 8'hFA, 8'hFF}, // R8 below threshold
    {4'd8, 8'hF9, 8'hF9, 4'b0011, 8'hF9, 8'hF9}, // R8 exactly at threshold
    {4'd8, 8'h00, 8'hF9, 4'b1001, 8'h00, 8'hFF}, // R8 halving drops below
    {4'd8, 8'h00, 8'hEE, 4'b1001, 8'h00, 8'hF6}, // R8 halved yet kept
    {4'd8, 8'h00, 8'h7A, 4'b0011, 8'h00, 8'hFF}, // R8 negative small
    {4'd8, 8'hFA, 8'hFA, 4'b0010, 8'hFA, 8'hFA}, // R8 clip disabled
    {4'd7, 8'hFE, 8'hF0, 4'b1000, 8'hFE, 8'hF7}, // R7 small send halved
    {4'd9, 8'hFE, 8'hFE, 4'b0111, 8'hFE, 8'hFF}  // R9 receive not clipped
  };

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] r, input logic [7:0] t, input logic [3:0] ctl);
    @(negedge clk);
    rx_in = r; tx_in = t;
    {rx_act, tx_act, att_n, clip_en} = ctl;
    smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "rx_out in reset", rx_out, 8'hFF);
    check("R1", "tx_out in reset", tx_out, 8'hFF);
    check("R1", "out_vld in reset", {7'd0, out_vld}, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", "rx_out after release", rx_out, 8'hFF);
    check("R1", "out_vld after release", {7'd0, out_vld}, 8'h00);

    for (int i = 0; i < 16; i++) begin
      string rq;
      rq = $sformatf("R%0d", VEC[i][39:36]);
      frame(VEC[i][35:28], VEC[i][27:20], VEC[i][19:16]);
      check(rq, $sformatf("row %0d rx_out", i), rx_out, VEC[i][15:8]);
      check(rq, $sformatf("row %0d tx_out", i), tx_out, VEC[i][7:0]);
      check("R2", $sformatf("row %0d out_vld", i), {7'd0, out_vld}, 8'h01);
      @(negedge clk);
      check("R2", $sformatf("row %0d out_vld drop", i), {7'd0, out_vld}, 8'h00);
    end

    // R2: inputs change with no strobe, outputs must hold
    frame(8'hA5, 8'h80, 4'b1000);
    smp_stb = 1'b0;
    rx_in = 8'h12; tx_in = 8'h34; att_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R2", "rx hold without strobe", rx_out, 8'hA5);
    check("R2", "tx hold without strobe", tx_out, 8'h90);
    check("R2", "no valid without strobe", {7'd0, out_vld}, 8'h00);

    // R1: reset mid-run returns to idle
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "rx_out re-reset", rx_out, 8'hFF);
    check("R1", "tx_out re-reset", tx_out, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule